// File: doc/BRIEF.md
# Chained Serial-Out Register Reader

This controller collects the contents of a string of daisy-chained 8-bit parallel-in/serial-out shift registers and presents them to the rest of the chip one byte at a time. On a start pulse it asserts an active-low capture line so that every register in the string latches its parallel inputs at once. It then releases the capture line and asserts an active-low shift enable. After that it toggles a shift clock until every bit of every register has passed the serial output nearest the controller.

Each bit is sampled at the end of a low clock phase, just before the rising edge that advances the string. The first bit is therefore read straight after capture without any clock edge. Bits are packed most-significant-first into a byte. Every eight bits the byte goes out with a one-cycle strobe and an index. Index 0 is the register closest to the controller. The length of each clock phase is set in system cycles by a divider input that is captured when the read starts. A one-cycle done pulse marks the end of the read.

Top module: `chain_reader`

## Requirements
- R1: During and after reset the capture line and shift enable are high (inactive), the shift clock is low, and the byte strobe and done are low.
- R2: After a start pulse the capture line goes low for exactly DIV+1 system cycles. DIV is the divider value present with start. The shift clock stays low and the enable stays high while capture is low.
- R3: From the release of capture until the read ends, the shift enable stays low. The shift clock is high only while the enable is low.
- R4: A read produces exactly NUM_DEV×8 rising shift-clock edges. Every high phase and every low phase lasts DIV+1 system cycles.
- R5: Each bit is sampled from the serial input while the shift clock is low, before the rising edge that advances the chain. The first bit, bit 7 of the nearest register, is taken with no clock edge after capture.
- R6: Bits are packed most-significant-first: the first bit of each group of eight becomes bit 7 of the byte.
- R7: Bytes come out with a one-cycle strobe. Their indexes run 0, 1, … NUM_DEV−1, and byte k holds the parallel inputs of the register k places from the controller.
- R8: Done pulses for one cycle after the final byte strobe. At that point the enable is high and the shift clock is low.
- R9: A start pulse during a read is ignored. The read completes unchanged and no second capture follows.
- R10: With two registers, the byte with index 0 forms the upper eight bits of a 16-bit word and index 1 the lower eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to read the chain |
| div | input | DIV_W | Clock phase length minus one, in system cycles |
| ser_in | input | 1 | Serial output of the nearest register |
| cap_n | output | 1 | Active-low parallel capture line |
| sclk | output | 1 | Shift clock to the chain |
| sen_n | output | 1 | Active-low shift enable |
| byte_data | output | 8 | Assembled byte |
| byte_vld | output | 1 | One-cycle strobe for byte_data |
| byte_idx | output | IDX_W | Register position of the byte, 0 nearest |
| done | output | 1 | One-cycle end-of-read pulse |

## Verification
The assertions assume that start is a single-cycle pulse and that the serial input changes only after a rising shift-clock edge or while capture is low. This is how a real chain answers the controller. The bench models the register string at the ports. The model shifts a short time after each rising sclk, so the sampled bit always has a settled value. The divider is held steady across each read, and random stimulus draws the divider from a small range so that long and short phases both occur.

// File: rtl/chain_rd_pkg.sv
package chain_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAP  = 2'd1,
        ST_LOW  = 2'd2,
        ST_HIGH = 2'd3
    } rd_state_e;
endpackage

// File: rtl/chain_phase_timer.sv
module chain_phase_timer #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } tmr_t;

    tmr_t r_d, r_q;

    assign tick = (r_q.cnt == div) && !restart;

    always_comb begin
        r_d = r_q;
        if (restart || tick) r_d.cnt = '0;
        else                 r_d.cnt = r_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // a phase never runs past its programmed length
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |-> r_q.cnt <= div);
endmodule

// File: rtl/chain_byte_packer.sv
module chain_byte_packer #(
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             bit_in,
    input  logic             close,
    input  logic [IDX_W-1:0] idx_in,
    output logic [7:0]       byte_data,
    output logic             byte_vld,
    output logic [IDX_W-1:0] byte_idx
);
    typedef struct packed {
        logic [7:0]       acc;
        logic [7:0]       data;
        logic             vld;
        logic [IDX_W-1:0] idx;
    } pk_t;

    pk_t r_d, r_q;
    logic [7:0] merged;

    assign merged = {r_q.acc[6:0], bit_in};

    always_comb begin
        r_d     = r_q;
        r_d.vld = 1'b0;
        if (take) begin
            if (close) begin
                r_d.data = merged;
                r_d.vld  = 1'b1;
                r_d.idx  = idx_in;
                r_d.acc  = '0;
            end else begin
                r_d.acc  = merged;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign byte_data = r_q.data;
    assign byte_vld  = r_q.vld;
    assign byte_idx  = r_q.idx;

    p_vld_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |=> !byte_vld);
endmodule

// File: rtl/chain_reader.sv
module chain_reader
    import chain_rd_pkg::*;
#(
    parameter int NUM_DEV = 2,
    parameter int DIV_W   = 4,
    parameter int IDX_W   = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] div,
    input  logic             ser_in,
    output logic             cap_n,
    output logic             sclk,
    output logic             sen_n,
    output logic [7:0]       byte_data,
    output logic             byte_vld,
    output logic [IDX_W-1:0] byte_idx,
    output logic             done
);
    localparam int TOTAL = NUM_DEV * 8;
    localparam int BIT_W = $clog2(TOTAL + 1);

    typedef struct packed {
        rd_state_e        st;
        logic [BIT_W-1:0] nbit;
        logic [DIV_W-1:0] div;
        logic             done;
    } ctl_t;

    ctl_t r_d, r_q;
    logic             tick;
    logic             take;
    logic             close;
    logic [BIT_W-1:0] grp;
    logic [IDX_W-1:0] idx;

    chain_phase_timer #(.DIV_W(DIV_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (r_q.st == ST_IDLE),
        .div     (r_q.div),
        .tick    (tick)
    );

    assign take  = (r_q.st == ST_LOW) && tick;
    assign close = (r_q.nbit[2:0] == 3'd7);
    assign grp   = r_q.nbit >> 3;
    assign idx   = grp[IDX_W-1:0];

    chain_byte_packer #(.IDX_W(IDX_W)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .bit_in    (ser_in),
        .close     (close),
        .idx_in    (idx),
        .byte_data (byte_data),
        .byte_vld  (byte_vld),
        .byte_idx  (byte_idx)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_CAP;
                    r_d.div  = div;
                    r_d.nbit = '0;
                end
            end
            ST_CAP: begin
                if (tick) r_d.st = ST_LOW;
            end
            ST_LOW: begin
                if (tick) begin
                    r_d.st   = ST_HIGH;
                    r_d.nbit = r_q.nbit + 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (r_q.nbit == BIT_W'(TOTAL)) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st   = ST_LOW;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign cap_n = (r_q.st != ST_CAP);
    assign sclk  = (r_q.st == ST_HIGH);
    assign sen_n = !((r_q.st == ST_LOW) || (r_q.st == ST_HIGH));
    assign done  = r_q.done;

    p_cap_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_n |-> (!sclk && sen_n));
    p_clk_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !sen_n);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sen_n && !sclk && cap_n));
    p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld |-> (int'(byte_idx) < NUM_DEV));
    p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sen_n && start) |=> cap_n);
endmodule

// File: tb/chain_reader_bench.sv
module chain_reader_bench;
    localparam int N     = 2;
    localparam int DIV_W = 4;
    localparam int TOT   = N * 8;
    localparam int IDX_W = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [DIV_W-1:0] div = '0;
    logic ser_in;
    logic cap_n, sclk, sen_n, byte_vld, done;
    logic [7:0] byte_data;
    logic [IDX_W-1:0] byte_idx;

    int total = 0;
    int bad = 0;

    logic [7:0]     dev [N];
    logic [TOT-1:0] chain = '0;
    logic           far_bit = 1'b0;

    always #2 clk = ~clk;

    chain_reader #(.NUM_DEV(N), .DIV_W(DIV_W)) u_chain_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .div(div), .ser_in(ser_in),
        .cap_n(cap_n), .sclk(sclk), .sen_n(sen_n), .byte_data(byte_data),
        .byte_vld(byte_vld), .byte_idx(byte_idx), .done(done)
    );

    // model of the register string; register 0 is nearest, its last stage drives ser_in
    function automatic logic [TOT-1:0] flat_image();
        logic [TOT-1:0] v = '0;
        for (int i = 0; i < N; i++) v[TOT-1-8*i -: 8] = dev[i];
        return v;
    endfunction

    always @(negedge cap_n) chain = flat_image();
    always @(posedge sclk) begin
        #1;
        if (!sen_n) chain = {chain[TOT-2:0], far_bit};
    end
    assign ser_in = chain[TOT-1];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_read(input logic [DIV_W-1:0] d, input bit poke);
        int cap_len = 0, edges = 0, cyc = 0, nbytes = 0;
        int hi_len = 0, lo_len = 0, last_vld = -1, done_cyc = -1;
        bit phase_ok = 1, en_ok = 1, order_ok = 1, started = 0;
        logic prev_sclk = 1'b0;
        logic [7:0] got [N];
        for (int i = 0; i < N; i++) got[i] = 8'h00;
        @(negedge clk);
        div = d;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cyc < 0 && cyc < 4000) begin
            if (!cap_n) cap_len++;
            if (!sen_n) started = 1;
            if (started && cap_n && sen_n && !done) en_ok = 0;
            if (sclk && !prev_sclk) begin
                edges++;
                if (lo_len != int'(d) + 1) phase_ok = 0;
                lo_len = 0;
            end
            if (!sclk && prev_sclk) begin
                if (hi_len != int'(d) + 1) phase_ok = 0;
                hi_len = 0;
            end
            if (sclk) hi_len++;
            else if (!sen_n) lo_len++;
            if (byte_vld) begin
                if (int'(byte_idx) != nbytes) order_ok = 0;
                if (nbytes < N) got[nbytes] = byte_data;
                nbytes++;
                last_vld = cyc;
            end
            if (done) begin
                done_cyc = cyc;
                check(sen_n && !sclk, "R8 done with enable idle", {sen_n, sclk}, 2'b10);
            end
            if (poke && edges == 3) start = 1'b1;
            else start = 1'b0;
            prev_sclk = sclk;
            cyc++;
            @(negedge clk);
        end
        start = 1'b0;
        if (cyc >= 4000) check(0, "R8 watchdog no done", cyc, 0);
        check(cap_len == int'(d) + 1, "R2 capture length", cap_len, int'(d) + 1);
        check(edges == TOT, "R4 rising edge count", edges, TOT);
        check(phase_ok, "R4 phase length", 0, 1);
        check(en_ok, "R3 enable held low", 0, 1);
        check(order_ok && nbytes == N, "R7 index order and count", nbytes, N);
        check(done_cyc > last_vld, "R8 done after last strobe", done_cyc, last_vld + 1);
        for (int i = 0; i < N; i++)
            check(got[i] == dev[i], $sformatf("R5 R6 byte %0d", i), got[i], dev[i]);
        check({got[0], got[1]} == {dev[0], dev[1]}, "R10 word order",
              {got[0], got[1]}, {dev[0], dev[1]});
        // after the read nothing restarts, even if start was poked mid-read
        repeat (2 * (int'(d) + 1) + 4) begin
            @(negedge clk);
            if (!cap_n || !sen_n || done) begin
                check(0, "R9 no second read", {cap_n, sen_n, done}, 3'b110);
                break;
            end
        end
        if (poke) check(cap_n && sen_n, "R9 start ignored mid-read", {cap_n, sen_n}, 2'b11);
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        for (int i = 0; i < N; i++) dev[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cap_n && !sclk && sen_n && !byte_vld && !done, "R1 reset outputs",
              {cap_n, sclk, sen_n, byte_vld, done}, 5'b10100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cap_n && !sclk && sen_n && !done, "R1 idle after reset",
              {cap_n, sclk, sen_n, done}, 4'b1010);

        // directed corners
        dev[0] = 8'h00; dev[1] = 8'h00; far_bit = 1'b1; run_read(4'd0, 0);
        dev[0] = 8'hFF; dev[1] = 8'hFF; far_bit = 1'b0; run_read(4'd1, 0);
        dev[0] = 8'h80; dev[1] = 8'h01; run_read(4'd2, 0);
        dev[0] = 8'h01; dev[1] = 8'h80; run_read(4'd15, 0);
        dev[0] = 8'hA5; dev[1] = 8'h3C; run_read(4'd3, 1);

        // random
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < N; i++) dev[i] = 8'($urandom);
            far_bit = 1'($urandom);
            run_read(DIV_W'($urandom % 6), (k % 4) == 1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule